// File: doc/BRIEF.md
# Serial EEPROM Emulator on a Two-Wire Bus

This block is a two-wire (I2C) bus target that behaves like a 256-byte serial EEPROM. A fast system clock oversamples the bus lines. The data line is driven open-drain through an output enable. Three strap inputs set the low bits of the device address, and a protect input locks the upper half of the storage against writes.

A master writes by sending a write header, one word-address byte and up to a page of data. The data is gathered in an 8-entry page buffer and stored in the array only when the master sends STOP. A programming window follows the store, and during that window the device answers no header. Reads can start at the internal pointer, or the master can first load the pointer with a write header and then send a repeated START and a read header. Reads continue byte by byte until the master answers with a NACK.

Top module: `ee_i2c_slave`

## Requirements
- R1: A header is acknowledged only when its top four bits are 1010 and bits 3..1 equal `dev_sel`. Bit 0 selects read (1) or write (0). Any other header is not acknowledged, and SDA stays released until the next START.
- R2: A write transfer (header, word address, data, STOP) stores the data, and a later read of that address returns it.
- R3: Within a page write, only address bits 2..0 advance after each data byte. Bits 7..3 stay fixed, so the data wraps inside the aligned 8-byte page.
- R4: When more than 8 data bytes are sent in one write, the later bytes overwrite the buffered bytes at the wrapped positions, and only the final contents are stored.
- R5: After a store, every header is refused for PROG_CYCLES clock cycles. Once that window ends, headers are acknowledged again.
- R6: A write header with a word address, followed by a repeated START and a read header, returns the byte at that word address.
- R7: In a multi-byte read, the address advances across the whole array and wraps from 0xFF to 0x00.
- R8: A read that starts without a word address returns the byte one past the last byte accessed.
- R9: While `wp` is high at STOP, a write aimed at addresses 0x80..0xFF stores nothing. Writes to 0x00..0x7F are still stored.
- R10: A write that has no data bytes, or that is cut off by a repeated START, stores nothing and starts no programming window.
- R11: After reset, SDA is released, every byte reads 0xFF, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull the data line low when 1 |
| dev_sel | input | 3 | Device address strap bits |
| wp | input | 1 | Protect the upper half of the array |

## Verification
The STOP that ends a page write does two things at once: it stores the buffer and it starts the programming window. The bench sends a new START and header right behind that STOP, so the decision to acknowledge the header falls while the fresh window is running. The bench judges this by seeing a refused header, then an acknowledged header after the window, and then reading back the wrapped page contents. A second overlap is tested the same way: a repeated START arrives while data is still buffered. Here the bench expects no store and no window, so the next header must be acknowledged at once.

// File: rtl/ee_pkg.sv
package ee_pkg;
  // 4-bit device type code carried in the top of every header
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WORD,
    S_WORD_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_RDAT,
    S_RDAT_ACK
  } ee_state_t;

  // Header match: type nibble plus strap bits (R/W bit excluded)
  function automatic logic header_hit(input logic [6:0] hdr, input logic [2:0] pins);
    return (hdr[6:3] == DEV_TYPE) && (hdr[2:0] == pins);
  endfunction
endpackage

// File: rtl/ee_bus_sense.sv
module ee_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_lv,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end
  end

  assign scl_hi   = scl_sync[1];
  assign sda_lv   = sda_sync[1];
  assign scl_rise = scl_hi & ~scl_q;
  assign scl_fall = ~scl_hi & scl_q;
  assign start_ev = scl_hi & scl_q & sda_q & ~sda_lv;
  assign stop_ev  = scl_hi & scl_q & ~sda_q & sda_lv;
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
  parameter int PROG_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             remain <= '0;
    else if (launch)        remain <= CNT_W'(PROG_CYCLES);
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int PAGE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    we,
  input  logic [PAGE_W-1:0]       idx,
  input  logic [7:0]              din,
  output logic [8*(1<<PAGE_W)-1:0] data_flat,
  output logic [(1<<PAGE_W)-1:0]  valid
);
  localparam int NB = 1 << PAGE_W;
  logic [7:0] slot [NB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      for (int i = 0; i < NB; i++) slot[i] <= '0;
    end else if (clr) begin
      valid <= '0;
    end else if (we) begin
      slot[idx]  <= din;
      valid[idx] <= 1'b1;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_flat
    assign data_flat[8*g +: 8] = slot[g];
  end
endmodule

// File: rtl/ee_store.sv
module ee_store #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [ADDR_W-PAGE_W-1:0]     page,
  input  logic [8*(1<<PAGE_W)-1:0]     wdata,
  input  logic [(1<<PAGE_W)-1:0]       wvalid,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [7:0]                   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NB    = 1 << PAGE_W;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) cells[a] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < NB; i++)
        if (wvalid[i]) cells[{page, PAGE_W'(i)}] <= wdata[8*i +: 8];
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int PROG_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] dev_sel,
  input  logic       wp
);
  import ee_pkg::*;
  localparam int NB     = 1 << PAGE_W;
  localparam int BANK_W = ADDR_W - PAGE_W;

  // advance only the in-page offset
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  logic scl_hi, sda_lv, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy;
  ee_state_t st;
  logic [3:0] bitcnt;
  logic [7:0] sreg;
  logic [ADDR_W-1:0] ptr;
  logic rw_q, wr_armed, mst_nack, sda_oe_q;
  logic [8*NB-1:0] buf_data;
  logic [NB-1:0] buf_valid;
  logic [7:0] rd_data;

  ee_bus_sense u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_lv(sda_lv), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  // named internal events
  logic byte_end, hdr_ack, word_end, data_end, commit_go;
  assign byte_end  = scl_fall && (bitcnt == 4'd8);
  assign hdr_ack   = (st == S_ADDR) && byte_end && header_hit(sreg[7:1], dev_sel) && !busy;
  assign word_end  = (st == S_WORD) && byte_end;
  assign data_end  = (st == S_WDAT) && byte_end;
  assign commit_go = stop_ev && wr_armed && (|buf_valid) && !(wp && ptr[ADDR_W-1]);

  ee_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(commit_go), .busy(busy)
  );

  ee_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(start_ev), .we(data_end),
    .idx(ptr[PAGE_W-1:0]), .din(sreg), .data_flat(buf_data), .valid(buf_valid)
  );

  ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit_go), .page(ptr[ADDR_W-1:PAGE_W]),
    .wdata(buf_data), .wvalid(buf_valid), .rd_addr(ptr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      sreg     <= '0;
      ptr      <= '0;
      rw_q     <= 1'b0;
      wr_armed <= 1'b0;
      mst_nack <= 1'b1;
      sda_oe_q <= 1'b0;
    end else if (start_ev) begin
      st       <= S_ADDR;
      bitcnt   <= '0;
      sda_oe_q <= 1'b0;
      wr_armed <= 1'b0;
    end else if (stop_ev) begin
      st       <= S_IDLE;
      sda_oe_q <= 1'b0;
      wr_armed <= 1'b0;
    end else begin
      unique case (st)
        S_ADDR, S_WORD, S_WDAT: begin
          if (scl_rise) begin
            sreg   <= {sreg[6:0], sda_lv};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            if (st == S_ADDR) begin
              if (hdr_ack) begin
                sda_oe_q <= 1'b1;
                rw_q     <= sreg[0];
                st       <= S_ADDR_ACK;
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_WORD) begin
              ptr      <= sreg[ADDR_W-1:0];
              wr_armed <= 1'b1;
              sda_oe_q <= 1'b1;
              st       <= S_WORD_ACK;
            end else begin
              ptr      <= page_next(ptr);
              sda_oe_q <= 1'b1;
              st       <= S_WDAT_ACK;
            end
          end
        end
        S_ADDR_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rw_q) begin
            sreg     <= rd_data;
            sda_oe_q <= ~rd_data[7];
            st       <= S_RDAT;
          end else begin
            sda_oe_q <= 1'b0;
            st       <= S_WORD;
          end
        end
        S_WORD_ACK, S_WDAT_ACK: if (scl_fall) begin
          sda_oe_q <= 1'b0;
          bitcnt   <= '0;
          st       <= S_WDAT;
        end
        S_RDAT: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe_q <= 1'b0;
              ptr      <= ptr + 1'b1;
              st       <= S_RDAT_ACK;
            end else begin
              sda_oe_q <= ~sreg[6];
              sreg     <= {sreg[6:0], 1'b0};
            end
          end
        end
        S_RDAT_ACK: begin
          if (scl_rise) begin
            mst_nack <= sda_lv;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (!mst_nack) begin
              sreg     <= rd_data;
              sda_oe_q <= ~rd_data[7];
              st       <= S_RDAT;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sda_oe = sda_oe_q;
endmodule

// File: rtl/ee_i2c_slave_chk.sv
module ee_i2c_slave_chk #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input ee_pkg::ee_state_t st,
  input logic              scl_hi,
  input logic              sda_oe,
  input logic              busy,
  input logic              commit_go,
  input logic              data_end,
  input logic [ADDR_W-1:0] ptr
);
  import ee_pkg::*;

  // R1: released line whenever no transfer is addressed to this device
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  // R1: the data line is only changed while the clock line is low
  p_sda_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_hi);

  // R5: no header acknowledge phase while programming
  p_ack_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR_ACK) |-> !busy);

  // R5: a store opens the programming window
  p_commit_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> busy);

  // R3: page bits stay put while data bytes arrive
  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_end |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
endmodule

bind ee_i2c_slave ee_i2c_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .scl_hi(scl_hi), .sda_oe(sda_oe),
  .busy(busy), .commit_go(commit_go), .data_end(data_end), .ptr(ptr)
);

// File: tb/test_ee_i2c_slave.sv
module test_ee_i2c_slave;
  localparam int Q    = 8;
  localparam int PROG = 400;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] HW = {4'b1010, PINS, 1'b0};
  localparam logic [7:0] HR = {4'b1010, PINS, 1'b1};
  // {wp, address, data, expected readback}
  localparam logic [24:0] VEC [4] = '{
    {1'b0, 8'h05, 8'h3C, 8'h3C},
    {1'b0, 8'h90, 8'hA7, 8'hA7},
    {1'b1, 8'h91, 8'h55, 8'hFF},
    {1'b1, 8'h12, 8'h66, 8'h66}
  };

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1, wp_r = 0;
  logic sda_oe, sda_bus;
  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  ee_i2c_slave #(.PROG_CYCLES(PROG)) i_ee_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .dev_sel(PINS), .wp(wp_r)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; hp(); scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; hp(); endtask
  task automatic bus_stop(); sda_m = 0; hp(); scl_m = 1; hp(); sda_m = 1; hp(); endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1; hp(); hp(); scl_m = 0; hp();
    end
    sda_m = 1; hp(); scl_m = 1; hp(); ack = ~sda_bus; hp(); scl_m = 0; hp();
  endtask

  task automatic rx_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1; hp(); b[i] = sda_bus; hp(); scl_m = 0;
    end
    hp(); sda_m = give_ack ? 1'b0 : 1'b1; hp(); scl_m = 1; hp(); hp(); scl_m = 0; hp(); sda_m = 1;
  endtask

  task automatic write_mem(input logic [7:0] addr, input int n, output logic ok);
    logic a;
    bus_start(); tx_byte(HW, a); ok = a;
    tx_byte(addr, a); ok &= a;
    for (int i = 0; i < n; i++) begin tx_byte(wbuf[i], a); ok &= a; end
    bus_stop();
  endtask

  task automatic read_mem(input logic [7:0] addr, input int n, output logic ok);
    logic a;
    bus_start(); tx_byte(HW, a); ok = a;
    tx_byte(addr, a); ok &= a;
    bus_start(); tx_byte(HR, a); ok &= a;
    for (int i = 0; i < n; i++) rx_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic probe(output logic a);
    bus_start(); tx_byte(HW, a); bus_stop();
  endtask

  initial begin
    repeat (PROG * 400) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic ok, a;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    chk("R11 sda released in reset", {7'b0, sda_oe}, 8'h00);
    rst_n = 1;
    hp();
    chk("R11 sda released after reset", {7'b0, sda_oe}, 8'h00);
    // R11/R8: read at pointer 0 of an erased array
    bus_start(); tx_byte(HR, a); rx_byte(1'b0, b); bus_stop();
    chk("R11 header ack after reset", {7'b0, a}, 8'h01);
    chk("R11 erased byte", b, 8'hFF);

    // R1: strap mismatch and type mismatch
    bus_start(); tx_byte({4'b1010, 3'b000, 1'b0}, a);
    chk("R1 strap mismatch nack", {7'b0, a}, 8'h00);
    tx_byte(8'h00, a);
    chk("R1 ignored rest of transfer", {7'b0, a}, 8'h00);
    bus_stop();
    bus_start(); tx_byte({4'b1011, PINS, 1'b0}, a); bus_stop();
    chk("R1 type mismatch nack", {7'b0, a}, 8'h00);

    // R2/R6/R9: vector table of byte writes and random reads
    foreach (VEC[k]) begin
      wp_r = VEC[k][24];
      wbuf[0] = VEC[k][15:8];
      write_mem(VEC[k][23:16], 1, ok);
      chk("R2 write acks", {7'b0, ok}, 8'h01);
      wp_r = 0;
      repeat (PROG + 50) @(negedge clk);
      read_mem(VEC[k][23:16], 1, ok);
      chk(VEC[k][24] ? "R9 protect readback" : "R6 random readback", rbuf[0], VEC[k][7:0]);
    end

    // R3: page write wraps in page; R5: busy window right after STOP
    wbuf[0] = 8'hD0; wbuf[1] = 8'hD1; wbuf[2] = 8'hD2; wbuf[3] = 8'hD3;
    write_mem(8'h1E, 4, ok);
    probe(a);
    chk("R5 header refused while programming", {7'b0, a}, 8'h00);
    repeat (PROG) @(negedge clk);
    probe(a);
    chk("R5 header accepted after window", {7'b0, a}, 8'h01);
    read_mem(8'h18, 8, ok);
    chk("R3 wrap slot 0x18", rbuf[0], 8'hD2);
    chk("R3 wrap slot 0x19", rbuf[1], 8'hD3);
    chk("R3 untouched 0x1A", rbuf[2], 8'hFF);
    chk("R3 first byte 0x1E", rbuf[6], 8'hD0);
    chk("R3 second byte 0x1F", rbuf[7], 8'hD1);

    // R4: ten bytes into one page
    for (int i = 0; i < 10; i++) wbuf[i] = 8'h60 + 8'(i);
    write_mem(8'h40, 10, ok);
    repeat (PROG + 50) @(negedge clk);
    read_mem(8'h40, 3, ok);
    chk("R4 overwrite slot 0", rbuf[0], 8'h68);
    chk("R4 overwrite slot 1", rbuf[1], 8'h69);
    chk("R4 kept slot 2", rbuf[2], 8'h62);

    // R7/R8: full-array wrap and current-address read
    wbuf[0] = 8'h11; wbuf[1] = 8'h33;
    write_mem(8'h00, 2, ok);
    repeat (PROG + 50) @(negedge clk);
    wbuf[0] = 8'h22;
    write_mem(8'hFF, 1, ok);
    repeat (PROG + 50) @(negedge clk);
    read_mem(8'hFF, 2, ok);
    chk("R7 last byte", rbuf[0], 8'h22);
    chk("R7 wrap to zero", rbuf[1], 8'h11);
    bus_start(); tx_byte(HR, a); rx_byte(1'b0, b); bus_stop();
    chk("R8 current address read", b, 8'h33);

    // R10: repeated START aborts buffered data; word-only write
    bus_start(); tx_byte(HW, a); tx_byte(8'h50, a); tx_byte(8'h77, a);
    bus_start(); tx_byte(HR, a); rx_byte(1'b0, b); bus_stop();
    chk("R10 read after abort", b, 8'hFF);
    probe(a);
    chk("R10 no window after abort", {7'b0, a}, 8'h01);
    bus_start(); tx_byte(HW, a); tx_byte(8'h60, a); bus_stop();
    probe(a);
    chk("R10 no window after word-only write", {7'b0, a}, 8'h01);
    read_mem(8'h50, 1, ok);
    chk("R10 aborted data not stored", rbuf[0], 8'hFF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule